// File: doc/BRIEF.md
# CAN controller host register and interrupt block

This block is the byte-wide register interface that a host processor sees on an extended-frame CAN controller. It holds the mode register with its reset-mode bit, a write-only command register, a status register, an interrupt register with its enable mask, and a 13-byte window. In reset mode the window holds the acceptance code and mask bytes. In operating mode, writes to the window fill the transmit buffer and reads from it show the bytes at the head of the receive FIFO.

The block does not move frames itself. It pulses a transmit request with the buffer contents attached, and it takes a completion pulse back. It turns the receive engine's start, store, reject and overrun pulses into status and interrupt bits. It keeps a count of the messages waiting to be read, and it pulses a release towards the FIFO when the host frees a message. When the host leaves reset mode, the block latches the acceptance configuration for the filter and pulses a flush.

Writes take effect at the next clock edge. Read data is registered and is valid in the cycle after `rd_en`. The interrupt line is a register that changes at the same edge as the interrupt register.

Top module: `canreg_host_if`

## Requirements
- R1: After synchronous reset, mode reads 0x01 (reset mode), status reads 0x3C, the interrupt register reads 0x00, and `irq_o` and `tx_req_o` are low.
- R2: A mode write (address 0) stores only bits 4:0. A write with bit 0 = 0 while bit 0 is 1 leaves reset mode. In the next cycle `filt_load_o` and `rx_flush_o` pulse high for one cycle. At the same time `filt_cfg_o` takes the eight code/mask bytes (byte i on bits 8i+7:8i), `filt_single_o` takes bit 3 of the written value, and the pending-message count goes to zero.
- R3: In reset mode, addresses 16–23 read and write code/mask bytes 0–7, addresses 24–28 read 0x00, and window writes leave `tx_buf_o` unchanged.
- R4: In operating mode, a write to address 16+k stores transmit byte k on `tx_buf_o[8k+7:8k]`. A read of 16+k drives `fifo_idx_o` = k and returns `fifo_byte_i`.
- R5: Any write to address 16 sets status bit 5 (transmit in progress).
- R6: Command bit 0 pulses `tx_req_o` in the next cycle and clears status bits 2 (transmit complete) and 3 (buffer free). A `tx_done_i` pulse sets bits 2 and 3, clears status bit 5 and sets interrupt bit 1.
- R7: Command bit 2, with messages pending, pulses `rx_release_o` in the next cycle and reduces the count by one. When the count reaches zero, interrupt bit 0 clears. With no messages pending, command bit 2 gives no pulse.
- R8: `rx_overrun_i` sets status bit 1 and interrupt bit 3. Command bit 3 clears both. The command register reads 0x00.
- R9: Reading the interrupt register (address 3) returns its value and clears it. Bit 0 is set again at once if messages are still pending.
- R10: `irq_o` is high exactly when the interrupt-enable register (address 4) ANDed with the interrupt register is nonzero. It changes in the same cycle as either of them.
- R11: `rx_start_i` sets status bit 4. `rx_store_i`, `rx_reject_i` and `rx_overrun_i` clear it. `rx_store_i` adds a message and sets interrupt bit 0. Status bit 0 is high while the count is nonzero.
- R12: Addresses 5–15 read 0x00 and writes to them are ignored. Addresses 29–31 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data, valid the cycle after rd_en |
| irq_o | output | 1 | Active-high interrupt |
| tx_req_o | output | 1 | One-cycle transmit request |
| tx_buf_o | output | NTX*DW | Transmit buffer bytes, byte k at 8k |
| tx_done_i | input | 1 | Transmit complete pulse |
| rx_start_i | input | 1 | Frame reception started |
| rx_store_i | input | 1 | Frame stored in FIFO |
| rx_reject_i | input | 1 | Frame rejected by filter |
| rx_overrun_i | input | 1 | Frame lost, FIFO full |
| rx_release_o | output | 1 | Pulse: free head message in FIFO |
| rx_flush_o | output | 1 | Pulse: clear FIFO counters on leaving reset mode |
| fifo_idx_o | output | $clog2(NTX) | Byte offset of FIFO read |
| fifo_byte_i | input | DW | FIFO byte at fifo_idx_o |
| filt_load_o | output | 1 | Pulse: filter configuration latched |
| filt_cfg_o | output | NCM*DW | Latched code/mask bytes |
| filt_single_o | output | 1 | Latched single-filter mode bit |

## Verification
The bench builds the block with its default parameters. These are 5-bit addresses, byte data, eight code/mask bytes, a 13-byte window and a 7-bit message count. With these values the full window, from address 16 to 28, is used, as are the gap of 24–28 in reset mode and the unmapped addresses above it. A FIFO model returns a pattern that depends on the offset, so `fifo_idx_o` shows up in the read data. The bench follows the status, interrupt and message count through the transmit, receive, release, overrun and mode-change sequences.

// File: rtl/canreg_pkg.sv
package canreg_pkg;
  // register addresses; the host software layout depends on these
  localparam int unsigned A_MODE   = 0;
  localparam int unsigned A_CMD    = 1;
  localparam int unsigned A_STAT   = 2;
  localparam int unsigned A_INTR   = 3;
  localparam int unsigned A_IEN    = 4;
  localparam int unsigned A_RSV_LO = 5;
  localparam int unsigned A_RSV_HI = 15;
  localparam int unsigned A_WIN_LO = 16;
  localparam int unsigned A_WIN_HI = 28;

  // mode bits
  localparam int unsigned MODE_RST    = 0;
  localparam int unsigned MODE_SINGLE = 3;

  // command bits
  localparam int unsigned CMD_TX     = 0;
  localparam int unsigned CMD_REL    = 2;
  localparam int unsigned CMD_CLROVR = 3;

  // status bits
  localparam int unsigned ST_RXRDY  = 0;
  localparam int unsigned ST_OVR    = 1;
  localparam int unsigned ST_TXDONE = 2;
  localparam int unsigned ST_TXFREE = 3;
  localparam int unsigned ST_RXACT  = 4;
  localparam int unsigned ST_TXACT  = 5;

  // interrupt bits
  localparam int unsigned IR_RX  = 0;
  localparam int unsigned IR_TX  = 1;
  localparam int unsigned IR_OVR = 3;

  typedef struct packed {
    logic tx_go;
    logic release_rx;
    logic clr_ovr;
  } cmd_t;
endpackage

// File: rtl/canreg_window.sv
module canreg_window #(
  parameter int unsigned DW  = 8,
  parameter int unsigned NCM = 8,
  parameter int unsigned NTX = 13,
  parameter int unsigned IW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cm_we,
  input  logic              tx_we,
  input  logic [IW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [NCM*DW-1:0] cm_flat,
  output logic [NTX*DW-1:0] tx_flat,
  output logic [DW-1:0]     cm_rd
);
  logic [DW-1:0] cm_q [NCM];
  logic [DW-1:0] tx_q [NTX];

  for (genvar i = 0; i < NCM; i++) begin : g_cm
    always_ff @(posedge clk) begin
      if (rst) cm_q[i] <= '0;
      else if (cm_we && idx == IW'(i)) cm_q[i] <= wdata;
    end
    assign cm_flat[i*DW +: DW] = cm_q[i];
  end

  for (genvar j = 0; j < NTX; j++) begin : g_tx
    always_ff @(posedge clk) begin
      if (rst) tx_q[j] <= '0;
      else if (tx_we && idx == IW'(j)) tx_q[j] <= wdata;
    end
    assign tx_flat[j*DW +: DW] = tx_q[j];
  end

  // offsets past the code/mask bytes read as zero
  always_comb begin
    cm_rd = '0;
    for (int k = 0; k < NCM; k++) begin
      if (idx == IW'(k)) cm_rd = cm_q[k];
    end
  end
endmodule

// File: rtl/canreg_events.sv
module canreg_events import canreg_pkg::*; #(
  parameter int unsigned DW  = 8,
  parameter int unsigned MCW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ev_tx_go,
  input  logic           ev_tx_done,
  input  logic           ev_release,
  input  logic           ev_clr_ovr,
  input  logic           ev_intr_rd,
  input  logic           ev_flush,
  input  logic           ev_ien_we,
  input  logic           ev_txact_set,
  input  logic [DW-1:0]  wdata,
  input  logic           rx_start,
  input  logic           rx_store,
  input  logic           rx_reject,
  input  logic           rx_overrun,
  output logic [DW-1:0]  status_o,
  output logic [DW-1:0]  intr_o,
  output logic [DW-1:0]  ien_o,
  output logic           irq_o,
  output logic           release_o,
  output logic [MCW-1:0] msg_o
);
  localparam logic [DW-1:0] ST_RST = DW'((1 << ST_TXDONE) | (1 << ST_TXFREE) |
                                         (1 << ST_RXACT) | (1 << ST_TXACT));

  logic [DW-1:0]  st_q, st_d, ir_q, ir_d, ien_q, ien_d;
  logic [MCW-1:0] msg_q, msg_d;
  logic           irq_q, rel_q, pend, do_rel;

  assign pend   = (msg_q != '0);
  assign do_rel = ev_release && pend;

  always_comb begin
    msg_d = msg_q;
    if (ev_flush) msg_d = '0;
    else if (rx_store && !do_rel) begin
      if (msg_q != '1) msg_d = msg_q + 1'b1;
    end else if (do_rel && !rx_store) msg_d = msg_q - 1'b1;

    ir_d = ev_intr_rd ? '0 : ir_q;
    if (rx_store) ir_d[IR_RX] = 1'b1;
    if (ev_intr_rd && msg_d != '0) ir_d[IR_RX] = 1'b1;
    if (do_rel && msg_d == '0) ir_d[IR_RX] = 1'b0;
    if (ev_tx_done) ir_d[IR_TX] = 1'b1;
    if (ev_clr_ovr) ir_d[IR_OVR] = 1'b0;
    if (rx_overrun) ir_d[IR_OVR] = 1'b1;

    st_d = st_q;
    if (rx_start) st_d[ST_RXACT] = 1'b1;
    if (rx_store || rx_reject || rx_overrun) st_d[ST_RXACT] = 1'b0;
    if (ev_clr_ovr) st_d[ST_OVR] = 1'b0;
    if (rx_overrun) st_d[ST_OVR] = 1'b1;
    if (ev_tx_go) begin
      st_d[ST_TXDONE] = 1'b0;
      st_d[ST_TXFREE] = 1'b0;
    end
    if (ev_tx_done) begin
      st_d[ST_TXDONE] = 1'b1;
      st_d[ST_TXFREE] = 1'b1;
      st_d[ST_TXACT]  = 1'b0;
    end
    if (ev_txact_set) st_d[ST_TXACT] = 1'b1;
    st_d[ST_RXRDY] = (msg_d != '0);

    ien_d = ev_ien_we ? wdata : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RST;
      ir_q  <= '0;
      ien_q <= '0;
      msg_q <= '0;
      irq_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ir_q  <= ir_d;
      ien_q <= ien_d;
      msg_q <= msg_d;
      irq_q <= |(ien_d & ir_d);
      rel_q <= do_rel;
    end
  end

  assign status_o  = st_q;
  assign intr_o    = ir_q;
  assign ien_o     = ien_q;
  assign irq_o     = irq_q;
  assign release_o = rel_q;
  assign msg_o     = msg_q;
endmodule

// File: rtl/canreg_host_if.sv
module canreg_host_if import canreg_pkg::*; #(
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 8,
  parameter int unsigned NCM = 8,
  parameter int unsigned NTX = 13,
  parameter int unsigned MCW = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     irq_o,
  output logic                     tx_req_o,
  output logic [NTX*DW-1:0]        tx_buf_o,
  input  logic                     tx_done_i,
  input  logic                     rx_start_i,
  input  logic                     rx_store_i,
  input  logic                     rx_reject_i,
  input  logic                     rx_overrun_i,
  output logic                     rx_release_o,
  output logic                     rx_flush_o,
  output logic [$clog2(NTX)-1:0]   fifo_idx_o,
  input  logic [DW-1:0]            fifo_byte_i,
  output logic                     filt_load_o,
  output logic [NCM*DW-1:0]        filt_cfg_o,
  output logic                     filt_single_o
);
  localparam int unsigned IW = $clog2(NTX);
  localparam logic [AW-1:0] AD_MODE   = AW'(A_MODE);
  localparam logic [AW-1:0] AD_CMD    = AW'(A_CMD);
  localparam logic [AW-1:0] AD_STAT   = AW'(A_STAT);
  localparam logic [AW-1:0] AD_INTR   = AW'(A_INTR);
  localparam logic [AW-1:0] AD_IEN    = AW'(A_IEN);
  localparam logic [AW-1:0] AD_RSV_LO = AW'(A_RSV_LO);
  localparam logic [AW-1:0] AD_RSV_HI = AW'(A_RSV_HI);
  localparam logic [AW-1:0] AD_WIN_LO = AW'(A_WIN_LO);
  localparam logic [AW-1:0] AD_WIN_HI = AW'(A_WIN_HI);

  logic [4:0]        mode_q;
  logic [DW-1:0]     rdata_q, rd_d;
  logic              tx_req_q, filt_load_q, flush_q, filt_single_q;
  logic [NCM*DW-1:0] filt_cfg_q, cm_flat;
  logic [DW-1:0]     cm_rd, st_w, intr_w, ien_w;
  logic [MCW-1:0]    msg_w;
  logic [IW-1:0]     widx;
  logic              in_win, rst_mode, cm_we, tx_we, mode_we, leave, cmd_we;
  cmd_t              cmd;

  assign rst_mode = mode_q[MODE_RST];
  assign in_win   = (addr >= AD_WIN_LO) && (addr <= AD_WIN_HI);
  assign widx     = IW'(addr - AD_WIN_LO);
  assign cm_we    = wr_en && in_win && rst_mode && (32'(widx) < NCM);
  assign tx_we    = wr_en && in_win && !rst_mode;
  assign mode_we  = wr_en && (addr == AD_MODE);
  assign leave    = mode_we && rst_mode && !wdata[MODE_RST];
  assign cmd_we   = wr_en && (addr == AD_CMD);

  assign cmd.tx_go      = cmd_we && wdata[CMD_TX];
  assign cmd.release_rx = cmd_we && wdata[CMD_REL];
  assign cmd.clr_ovr    = cmd_we && wdata[CMD_CLROVR];

  canreg_window #(.DW(DW), .NCM(NCM), .NTX(NTX), .IW(IW)) u_win (
    .clk(clk), .rst(rst), .cm_we(cm_we), .tx_we(tx_we), .idx(widx),
    .wdata(wdata), .cm_flat(cm_flat), .tx_flat(tx_buf_o), .cm_rd(cm_rd)
  );

  canreg_events #(.DW(DW), .MCW(MCW)) u_ev (
    .clk(clk), .rst(rst),
    .ev_tx_go(cmd.tx_go), .ev_tx_done(tx_done_i),
    .ev_release(cmd.release_rx), .ev_clr_ovr(cmd.clr_ovr),
    .ev_intr_rd(rd_en && (addr == AD_INTR)), .ev_flush(leave),
    .ev_ien_we(wr_en && (addr == AD_IEN)),
    .ev_txact_set(wr_en && (addr == AD_WIN_LO)),
    .wdata(wdata), .rx_start(rx_start_i), .rx_store(rx_store_i),
    .rx_reject(rx_reject_i), .rx_overrun(rx_overrun_i),
    .status_o(st_w), .intr_o(intr_w), .ien_o(ien_w), .irq_o(irq_o),
    .release_o(rx_release_o), .msg_o(msg_w)
  );

  always_comb begin
    rd_d = '1;
    if (addr == AD_MODE)      rd_d = DW'(mode_q);
    else if (addr == AD_CMD)  rd_d = '0;
    else if (addr == AD_STAT) rd_d = st_w;
    else if (addr == AD_INTR) rd_d = intr_w;
    else if (addr == AD_IEN)  rd_d = ien_w;
    else if (addr >= AD_RSV_LO && addr <= AD_RSV_HI) rd_d = '0;
    else if (in_win)          rd_d = rst_mode ? cm_rd : fifo_byte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= 5'b00001;
      rdata_q       <= '0;
      tx_req_q      <= 1'b0;
      filt_load_q   <= 1'b0;
      flush_q       <= 1'b0;
      filt_cfg_q    <= '0;
      filt_single_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= wdata[4:0];
      if (rd_en) rdata_q <= rd_d;
      tx_req_q    <= cmd.tx_go;
      filt_load_q <= leave;
      flush_q     <= leave;
      if (leave) begin
        filt_cfg_q    <= cm_flat;
        filt_single_q <= wdata[MODE_SINGLE];
      end
    end
  end

  assign rdata         = rdata_q;
  assign tx_req_o      = tx_req_q;
  assign fifo_idx_o    = widx;
  assign filt_load_o   = filt_load_q;
  assign rx_flush_o    = flush_q;
  assign filt_cfg_o    = filt_cfg_q;
  assign filt_single_o = filt_single_q;
endmodule

// File: rtl/canreg_host_if_chk.sv
module canreg_host_if_chk #(
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 8,
  parameter int unsigned MCW = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           tx_done_i,
  input logic           rx_overrun_i,
  input logic           rx_release_o,
  input logic           rx_flush_o,
  input logic           irq_o,
  input logic [DW-1:0]  st,
  input logic [DW-1:0]  intr,
  input logic [DW-1:0]  ien,
  input logic [MCW-1:0] msg
);
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(ien & intr)));

  a_r6_done_restores: assert property (@(posedge clk) disable iff (rst)
    (tx_done_i && !(wr_en && (addr == AW'(1) || addr == AW'(16))))
    |=> (st[2] && st[3] && !st[5] && intr[1]));

  a_r8_overrun_flags: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun_i && !(wr_en && addr == AW'(1))) |=> (st[1] && intr[3]));

  a_r7_release_needs_msg: assert property (@(posedge clk) disable iff (rst)
    rx_release_o |-> ($past(msg) != '0));

  a_r9_pending_keeps_rx: assert property (@(posedge clk) disable iff (rst)
    (msg != '0) |-> intr[0]);

  a_r2_flush_empties: assert property (@(posedge clk) disable iff (rst)
    rx_flush_o |-> (msg == '0));
endmodule

bind canreg_host_if canreg_host_if_chk #(.AW(AW), .DW(DW), .MCW(MCW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .tx_done_i(tx_done_i),
  .rx_overrun_i(rx_overrun_i), .rx_release_o(rx_release_o),
  .rx_flush_o(rx_flush_o), .irq_o(irq_o), .st(st_w), .intr(intr_w),
  .ien(ien_w), .msg(msg_w)
);

// File: tb/tb_canreg_host_if.sv
module tb_canreg_host_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_o, tx_req_o, rx_release_o, rx_flush_o, filt_load_o, filt_single_o;
  logic [103:0] tx_buf_o;
  logic tx_done_i = 1'b0, rx_start_i = 1'b0, rx_store_i = 1'b0;
  logic rx_reject_i = 1'b0, rx_overrun_i = 1'b0;
  logic [3:0] fifo_idx_o;
  logic [7:0] fifo_byte_i;
  logic [63:0] filt_cfg_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic mon_pend = 1'b0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  // FIFO model: byte depends on offset
  assign fifo_byte_i = 8'hA0 ^ {4'h0, fifo_idx_o};

  canreg_host_if dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .tx_req_o(tx_req_o),
    .tx_buf_o(tx_buf_o), .tx_done_i(tx_done_i), .rx_start_i(rx_start_i),
    .rx_store_i(rx_store_i), .rx_reject_i(rx_reject_i),
    .rx_overrun_i(rx_overrun_i), .rx_release_o(rx_release_o),
    .rx_flush_o(rx_flush_o), .fifo_idx_o(fifo_idx_o),
    .fifo_byte_i(fifo_byte_i), .filt_load_o(filt_load_o),
    .filt_cfg_o(filt_cfg_o), .filt_single_o(filt_single_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mon_pend <= rd_en && !rst;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      summary();
      $finish;
    end
  end

  // monitor: compare registered read data against the scoreboard
  always @(negedge clk) begin
    if (mon_pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk1(input string t, input logic act, input logic e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic chk8(input string t, input logic [7:0] act, input logic [7:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic chk64(input string t, input logic [63:0] act, input logic [63:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // 0 start, 1 store, 2 reject, 3 overrun, 4 tx done
  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: rx_start_i = 1'b1;
      1: rx_store_i = 1'b1;
      2: rx_reject_i = 1'b1;
      3: rx_overrun_i = 1'b1;
      default: tx_done_i = 1'b1;
    endcase
    @(negedge clk);
    rx_start_i = 1'b0; rx_store_i = 1'b0; rx_reject_i = 1'b0;
    rx_overrun_i = 1'b0; tx_done_i = 1'b0;
  endtask

  initial begin
    logic [63:0] exp_cfg;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk1("R1 irq", irq_o, 1'b0);
    chk1("R1 tx_req", tx_req_o, 1'b0);
    rd(5'd0, 8'h01, "R1 mode");
    rd(5'd2, 8'h3C, "R1 status");
    rd(5'd3, 8'h00, "R1 intr");

    // R12 reserved and unmapped, R8 command reads zero
    rd(5'd7, 8'h00, "R12 reserved read");
    wr(5'd9, 8'hAA);
    rd(5'd9, 8'h00, "R12 reserved write ignored");
    rd(5'd30, 8'hFF, "R12 unmapped");
    rd(5'd1, 8'h00, "R8 command reads zero");

    // R3 code/mask in reset mode
    for (int i = 0; i < 8; i++) wr(5'(16 + i), 8'(16 + i));
    rd(5'd18, 8'h12, "R3 code/mask 2");
    rd(5'd23, 8'h17, "R3 code/mask 7");
    rd(5'd26, 8'h00, "R3 gap reads zero");
    wr(5'd24, 8'h99);
    chk64("R3 tx buffer untouched", tx_buf_o[63:0], 64'h0);

    // R2 leave reset mode
    wr(5'd0, 8'hE8);
    for (int i = 0; i < 8; i++) exp_cfg[8*i +: 8] = 8'(16 + i);
    chk1("R2 filt_load", filt_load_o, 1'b1);
    chk1("R2 rx_flush", rx_flush_o, 1'b1);
    chk1("R2 filt_single", filt_single_o, 1'b1);
    chk64("R2 filt_cfg", filt_cfg_o, exp_cfg);
    rd(5'd0, 8'h08, "R2 mode keeps 4:0");
    chk1("R2 filt_load one cycle", filt_load_o, 1'b0);

    // R4 FIFO window reads
    rd(5'd20, 8'hA4, "R4 fifo byte 4");
    rd(5'd28, 8'hAC, "R4 fifo byte 12");

    // R11 receive status
    pulse(2);
    rd(5'd2, 8'h2C, "R11 reject clears rx active");
    pulse(0);
    rd(5'd2, 8'h3C, "R11 start sets rx active");
    pulse(1);
    rd(5'd2, 8'h2D, "R11 store sets rx ready");
    chk1("R10 irq masked", irq_o, 1'b0);
    wr(5'd4, 8'h03);
    chk1("R10 irq on enable", irq_o, 1'b1);

    // R4 transmit buffer, R6 transmit
    wr(5'd16, 8'h55);
    wr(5'd28, 8'h77);
    chk8("R4 tx byte 0", tx_buf_o[7:0], 8'h55);
    chk8("R4 tx byte 12", tx_buf_o[103:96], 8'h77);
    wr(5'd1, 8'h01);
    chk1("R6 tx_req pulse", tx_req_o, 1'b1);
    rd(5'd2, 8'h21, "R6 status during send");
    chk1("R6 tx_req one cycle", tx_req_o, 1'b0);
    pulse(4);
    rd(5'd2, 8'h0D, "R6 status after done");
    rd(5'd3, 8'h03, "R6 intr tx set");
    rd(5'd3, 8'h01, "R9 rx reasserted while pending");
    chk1("R10 irq pending rx", irq_o, 1'b1);

    // R5
    wr(5'd16, 8'h56);
    rd(5'd2, 8'h2D, "R5 write 16 sets tx status");

    // R7 release
    wr(5'd1, 8'h04);
    chk1("R7 release pulse", rx_release_o, 1'b1);
    rd(5'd2, 8'h2C, "R7 status empty");
    chk1("R10 irq low after release", irq_o, 1'b0);
    rd(5'd3, 8'h00, "R7 intr rx cleared");
    wr(5'd1, 8'h04);
    chk1("R7 no release when empty", rx_release_o, 1'b0);

    // R8 overrun
    pulse(3);
    rd(5'd2, 8'h2E, "R8 overrun status");
    chk1("R10 overrun masked", irq_o, 1'b0);
    wr(5'd4, 8'h08);
    chk1("R10 overrun enabled", irq_o, 1'b1);
    wr(5'd1, 8'h08);
    chk1("R8 irq after clear", irq_o, 1'b0);
    rd(5'd2, 8'h2C, "R8 overrun cleared");
    rd(5'd3, 8'h00, "R8 intr overrun cleared");

    // R2 leaving reset clears message count
    pulse(1);
    pulse(1);
    rd(5'd2, 8'h2D, "R11 two stored");
    wr(5'd0, 8'h01);
    chk1("R2 no flush entering reset", rx_flush_o, 1'b0);
    wr(5'd0, 8'h00);
    chk1("R2 flush on leave", rx_flush_o, 1'b1);
    rd(5'd2, 8'h2C, "R2 count cleared");
    rd(5'd3, 8'h01, "R9 read returns pending flag");
    rd(5'd3, 8'h00, "R9 cleared with no messages");

    // R3 reset mode window again
    wr(5'd0, 8'h01);
    wr(5'd16, 8'hC3);
    rd(5'd16, 8'hC3, "R3 code/mask 0 rewritten");
    chk8("R3 tx byte kept", tx_buf_o[7:0], 8'h56);
    wr(5'd0, 8'hFF);
    rd(5'd0, 8'h1F, "R2 mode masks upper bits");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule